// File: doc/BRIEF.md
# Rotate-and-Mask Unit

This block carries out the two word-sized "rotate left by an immediate, then mask" operations of a fixed-point execution pipe. The source word is rotated left by a 5-bit amount. A mask is built from a begin position and an end position, and the rotated word is passed through that mask. In the clearing form, every bit outside the mask becomes zero. In the merging form, every bit outside the mask is taken from the old destination value. When the record flag is set, the block also produces a 4-bit condition field that describes the result.

Bit positions for the mask use big-endian numbering: position 0 is the most significant bit of the word. When the begin position lies after the end position, the run of ones wraps around the end of the word. A parameter selects the output timing. With the first setting, the outputs follow the inputs in the same cycle. With the second, each valid input is captured and appears one clock later. A second parameter selects how the rotator is built.

Top module: `rotmask_unit`

## Requirements
- R1: `result` is `src_val` rotated left by `rot_amt` positions (0 to 31), before masking.
- R2: When `mask_begin` <= `mask_end`, the mask holds ones at positions `mask_begin` through `mask_end` and zeros elsewhere. Position p maps to vector bit 31-p.
- R3: When `mask_begin` > `mask_end`, the mask holds ones at positions `mask_begin` through 31 and at positions 0 through `mask_end`, and zeros elsewhere.
- R4: When `mask_begin` equals `mask_end`+1 modulo 32, the mask is all ones.
- R5: With `op_insert`=0, every `result` bit outside the mask is 0, and every bit inside it equals the rotated source.
- R6: With `op_insert`=1, every `result` bit outside the mask equals `dst_old`, and every bit inside it equals the rotated source.
- R7: `cr_field` is {LT, GT, EQ, SO} from bit 3 down to bit 0. LT is `result` bit 31. GT means the result is nonzero with bit 31 clear. EQ means the result is zero. SO copies `so_in`. Exactly one of LT, GT and EQ is set.
- R8: `cr_write` is 1 exactly when `out_valid` is 1 and the accepted operation had `rec_en`=1.
- R9: With REGISTERED=1, an operation presented with `in_valid`=1 appears on `result`, `cr_field`, `cr_write` and `out_valid` after the next rising clock edge. A cycle with `in_valid`=0 clears `out_valid` and leaves `result` unchanged.
- R10: With REGISTERED=1, while `rst_n` is low `out_valid`, `result`, `cr_field` and `cr_write` are all 0.
- R11: With REGISTERED=0, the outputs follow the inputs within the same cycle, and `out_valid` equals `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used when REGISTERED=1 |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present on the inputs |
| op_insert | input | 1 | 1 = merge with `dst_old`, 0 = clear outside the mask |
| src_val | input | WORD_W | Word to rotate |
| dst_old | input | WORD_W | Previous destination value, used by the merging form |
| rot_amt | input | SHAMT_W | Left rotate amount |
| mask_begin | input | SHAMT_W | First mask position (0 = MSB) |
| mask_end | input | SHAMT_W | Last mask position (0 = MSB) |
| rec_en | input | 1 | Request a condition field update |
| so_in | input | 1 | Summary-overflow bit to copy into the field |
| out_valid | output | 1 | Result valid |
| result | output | WORD_W | Rotated and masked word |
| cr_field | output | 4 | Condition field {LT, GT, EQ, SO} |
| cr_write | output | 1 | Condition field should be written |

## Verification
The bench builds two copies of the block. `u_dut` uses REGISTERED=1 with the log-staged rotator. `u_comb` uses REGISTERED=0 with the double-width shift rotator. Every vector therefore exercises both rotator structures and both output timings against the same expected words. The registered copy is the only one that exposes reset values, the one-cycle latency and the hold behaviour on idle cycles. The combinational copy is sampled before the clock edge, which shows that it has no hidden register.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;

   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
      logic so;
   } crf_t;

   localparam int unsigned CRF_W = $bits(crf_t);

endpackage

// File: rtl/rotmask_rotator.sv
module rotmask_rotator #(
   parameter int unsigned WORD_W = 32,
   parameter bit          STAGED = 1'b1,
   localparam int unsigned SHAMT_W = $clog2(WORD_W)
) (
   input  logic [WORD_W-1:0]  din,
   input  logic [SHAMT_W-1:0] amt,
   output logic [WORD_W-1:0]  dout
);

   generate
      if (STAGED) begin : g_staged
         logic [WORD_W-1:0] stage [0:SHAMT_W];
         assign stage[0] = din;
         for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
            localparam int unsigned STEP = 1 << k;
            always_comb begin
               if (amt[k])
                  stage[k+1] = {stage[k][WORD_W-STEP-1:0], stage[k][WORD_W-1:WORD_W-STEP]};
               else
                  stage[k+1] = stage[k];
            end
         end
         assign dout = stage[SHAMT_W];
      end else begin : g_double
         logic [2*WORD_W-1:0] wide;
         always_comb wide = {din, din} << amt;
         assign dout = wide[2*WORD_W-1:WORD_W];
      end
   endgenerate

endmodule

// File: rtl/rotmask_maskgen.sv
module rotmask_maskgen #(
   parameter int unsigned WORD_W = 32,
   localparam int unsigned SHAMT_W = $clog2(WORD_W)
) (
   input  logic [SHAMT_W-1:0] first_pos,
   input  logic [SHAMT_W-1:0] last_pos,
   output logic [WORD_W-1:0]  mask
);

   logic wraps;
   assign wraps = first_pos > last_pos;

   generate
      for (genvar p = 0; p < WORD_W; p++) begin : g_pos
         localparam logic [SHAMT_W-1:0] POS = SHAMT_W'(p);
         logic after_first, before_last;
         assign after_first = POS >= first_pos;
         assign before_last = POS <= last_pos;
         assign mask[WORD_W-1-p] = wraps ? (after_first | before_last)
                                         : (after_first & before_last);
      end
   endgenerate

   always_comb begin
      if (!$isunknown({first_pos, last_pos})) begin
         if (first_pos == SHAMT_W'(last_pos + 1'b1))
            a_r4_full_mask: assert (&mask);
         if (first_pos <= last_pos)
            a_r2_run_length: assert ($countones(mask) == int'(last_pos - first_pos) + 1);
         else
            a_r3_wrap_length: assert ($countones(mask) == int'(WORD_W) - int'(first_pos - last_pos) + 1);
      end
   end

endmodule

// File: rtl/rotmask_crgen.sv
module rotmask_crgen
   import rotmask_pkg::*;
#(
   parameter int unsigned WORD_W = 32
) (
   input  logic [WORD_W-1:0] value,
   input  logic              so,
   output crf_t              crf
);

   always_comb begin
      crf.lt = value[WORD_W-1];
      crf.eq = (value == '0);
      crf.gt = !value[WORD_W-1] && (value != '0);
      crf.so = so;
   end

   always_comb begin
      if (!$isunknown(value))
         a_r7_one_flag: assert ($onehot({crf.lt, crf.gt, crf.eq}));
   end

endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
   import rotmask_pkg::*;
#(
   parameter int unsigned WORD_W     = 32,
   parameter bit          REGISTERED = 1'b1,
   parameter bit          ROT_STAGED = 1'b1,
   localparam int unsigned SHAMT_W   = $clog2(WORD_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic               op_insert,
   input  logic [WORD_W-1:0]  src_val,
   input  logic [WORD_W-1:0]  dst_old,
   input  logic [SHAMT_W-1:0] rot_amt,
   input  logic [SHAMT_W-1:0] mask_begin,
   input  logic [SHAMT_W-1:0] mask_end,
   input  logic               rec_en,
   input  logic               so_in,
   output logic               out_valid,
   output logic [WORD_W-1:0]  result,
   output logic [CRF_W-1:0]   cr_field,
   output logic               cr_write
);

   generate
      if (WORD_W < 8 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_width
         $error("rotmask_unit: WORD_W must be a power of two of at least 8");
      end
   endgenerate

   logic [WORD_W-1:0] rotated;
   logic [WORD_W-1:0] mask;
   logic [WORD_W-1:0] merged;
   crf_t              crf_c;

   rotmask_rotator #(.WORD_W(WORD_W), .STAGED(ROT_STAGED)) u_rot (
      .din  (src_val),
      .amt  (rot_amt),
      .dout (rotated)
   );

   rotmask_maskgen #(.WORD_W(WORD_W)) u_mask (
      .first_pos (mask_begin),
      .last_pos  (mask_end),
      .mask      (mask)
   );

   always_comb begin
      if (op_insert)
         merged = (rotated & mask) | (dst_old & ~mask);
      else
         merged = rotated & mask;
   end

   rotmask_crgen #(.WORD_W(WORD_W)) u_cr (
      .value (merged),
      .so    (so_in),
      .crf   (crf_c)
   );

   always_comb begin
      if (!$isunknown({op_insert, src_val, dst_old, rot_amt, mask_begin, mask_end})) begin
         if (op_insert)
            a_r6_keep_old: assert ((merged & ~mask) == (dst_old & ~mask));
         else
            a_r5_clear_outside: assert ((merged & ~mask) == '0);
         a_r1_inside_rotated: assert ((merged & mask) == (rotated & mask));
      end
   end

   generate
      if (REGISTERED) begin : g_reg
         logic              vld_q;
         logic [WORD_W-1:0] res_q;
         crf_t              crf_q;
         logic              wr_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               res_q <= '0;
               crf_q <= '0;
               wr_q  <= 1'b0;
            end else begin
               vld_q <= in_valid;
               wr_q  <= in_valid & rec_en;
               if (in_valid) begin
                  res_q <= merged;
                  crf_q <= crf_c;
               end
            end
         end

         assign out_valid = vld_q;
         assign result    = res_q;
         assign cr_field  = crf_q;
         assign cr_write  = wr_q;

         a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(result));
         a_r9_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
         a_r8_write_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
            cr_write |-> out_valid);
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign out_valid = in_valid;
         assign result    = merged;
         assign cr_field  = crf_c;
         assign cr_write  = in_valid & rec_en;
      end
   endgenerate

endmodule

// File: tb/rotmask_unit_tb.sv
module rotmask_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        op_insert = 1'b0;
   logic [31:0] src_val = '0;
   logic [31:0] dst_old = '0;
   logic [4:0]  rot_amt = '0;
   logic [4:0]  mask_begin = '0;
   logic [4:0]  mask_end = '0;
   logic        rec_en = 1'b0;
   logic        so_in = 1'b0;

   logic        r_valid, c_valid, r_wr, c_wr;
   logic [31:0] r_res, c_res;
   logic [3:0]  r_cr, c_cr;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   rotmask_unit #(.WORD_W(32), .REGISTERED(1'b1), .ROT_STAGED(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_insert(op_insert),
      .src_val(src_val), .dst_old(dst_old), .rot_amt(rot_amt),
      .mask_begin(mask_begin), .mask_end(mask_end), .rec_en(rec_en), .so_in(so_in),
      .out_valid(r_valid), .result(r_res), .cr_field(r_cr), .cr_write(r_wr)
   );

   rotmask_unit #(.WORD_W(32), .REGISTERED(1'b0), .ROT_STAGED(1'b0)) u_comb (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_insert(op_insert),
      .src_val(src_val), .dst_old(dst_old), .rot_amt(rot_amt),
      .mask_begin(mask_begin), .mask_end(mask_end), .rec_en(rec_en), .so_in(so_in),
      .out_valid(c_valid), .result(c_res), .cr_field(c_cr), .cr_write(c_wr)
   );

   typedef struct packed {
      logic        ins;
      logic [31:0] rs;
      logic [31:0] ra;
      logic [4:0]  sh;
      logic [4:0]  mb;
      logic [4:0]  me;
      logic        rc;
      logic        so;
      logic [31:0] exp;
      logic [3:0]  cr;
   } vec_t;

   localparam int NVEC = 8;
   localparam vec_t VECS [NVEC] = '{
      // R1 R4: plain rotate by 8, full mask
      '{1'b0, 32'h12345678, 32'h0, 5'd8,  5'd0,  5'd31, 1'b1, 1'b0, 32'h34567812, 4'b0100},
      // R2: single low bit, rotate by 1
      '{1'b0, 32'h80000001, 32'h0, 5'd1,  5'd31, 5'd31, 1'b0, 1'b0, 32'h00000001, 4'b0100},
      // R3: wrapped mask positions 28..31 and 0..3
      '{1'b0, 32'hFFFFFFFF, 32'h0, 5'd0,  5'd28, 5'd3,  1'b1, 1'b1, 32'hF000000F, 4'b1001},
      // R6: insert top byte
      '{1'b1, 32'h000000AB, 32'hFFFFFFFF, 5'd24, 5'd0, 5'd7, 1'b1, 1'b0, 32'hABFFFFFF, 4'b1000},
      // R6: insert middle byte
      '{1'b1, 32'h0000FFFF, 32'h12345678, 5'd16, 5'd8, 5'd15, 1'b0, 1'b0, 32'h12FF5678, 4'b0100},
      // R4: begin = end + 1 gives all ones
      '{1'b0, 32'h0F0F0F0F, 32'h0, 5'd4,  5'd5,  5'd4,  1'b1, 1'b0, 32'hF0F0F0F0, 4'b1000},
      // R5 R7: zero result
      '{1'b0, 32'h0000FF00, 32'hFFFFFFFF, 5'd0, 5'd0, 5'd15, 1'b1, 1'b1, 32'h00000000, 4'b0011},
      // R2: single-bit mask at position 0, rotate by 31
      '{1'b0, 32'h00000001, 32'h0, 5'd31, 5'd0,  5'd0,  1'b1, 1'b0, 32'h80000000, 4'b1000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input vec_t v, input logic vld);
      @(negedge clk);
      in_valid   = vld;
      op_insert  = v.ins;
      src_val    = v.rs;
      dst_old    = v.ra;
      rot_amt    = v.sh;
      mask_begin = v.mb;
      mask_end   = v.me;
      rec_en     = v.rc;
      so_in      = v.so;
   endtask

   bit done = 1'b0;

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R10: reset state of the registered copy
      repeat (2) @(negedge clk);
      chk("R10 out_valid", {31'b0, r_valid}, 32'h0);
      chk("R10 result", r_res, 32'h0);
      chk("R10 cr_field", {28'b0, r_cr}, 32'h0);
      chk("R10 cr_write", {31'b0, r_wr}, 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         drive(VECS[i], 1'b1);
         #5;
         // R11: combinational copy settles before the clock edge
         chk("R11 comb result", c_res, VECS[i].exp);
         chk("R11 comb valid", {31'b0, c_valid}, 32'h1);
         chk("R8 comb cr_write", {31'b0, c_wr}, {31'b0, VECS[i].rc});
         if (VECS[i].rc)
            chk("R7 comb cr_field", {28'b0, c_cr}, {28'b0, VECS[i].cr});
         @(posedge clk);
         #5;
         // R1 R2 R3 R4 R5 R6 R9: registered copy one edge later
         chk("R9 reg result", r_res, VECS[i].exp);
         chk("R9 reg valid", {31'b0, r_valid}, 32'h1);
         chk("R8 reg cr_write", {31'b0, r_wr}, {31'b0, VECS[i].rc});
         if (VECS[i].rc)
            chk("R7 reg cr_field", {28'b0, r_cr}, {28'b0, VECS[i].cr});
      end

      // R9: idle cycle keeps the last result and drops valid
      drive('{1'b1, 32'hDEADBEEF, 32'h0, 5'd4, 5'd0, 5'd31, 1'b1, 1'b0, 32'h0, 4'h0}, 1'b0);
      #5;
      chk("R11 comb valid low", {31'b0, c_valid}, 32'h0);
      chk("R1 comb rotate 4", c_res, 32'hEADBEEFD);
      @(posedge clk);
      #5;
      chk("R9 hold result", r_res, 32'h80000000);
      chk("R9 valid drops", {31'b0, r_valid}, 32'h0);
      chk("R8 no write when idle", {31'b0, r_wr}, 32'h0);

      // R5: clearing form ignores dst_old entirely
      drive('{1'b0, 32'h00000000, 32'hFFFFFFFF, 5'd0, 5'd16, 5'd15, 1'b1, 1'b0, 32'h0, 4'h0}, 1'b1);
      @(posedge clk);
      #5;
      chk("R5 dst_old ignored", r_res, 32'h00000000);
      chk("R7 zero field", {28'b0, r_cr}, 32'h2);

      // R10: reset again clears the registered outputs
      @(negedge clk);
      rst_n = 1'b0;
      #5;
      chk("R10 reset clears valid", {31'b0, r_valid}, 32'h0);
      chk("R10 reset clears cr_write", {31'b0, r_wr}, 32'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule